// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

This block is an I2C target that looks to a bus master like a small byte-wide serial EEPROM. It holds a 2^ADDR_W byte array (256 bytes by default) and answers one fixed 7-bit device identity. A master writes one byte by sending the device identity with R/W low, then a word address, then a data byte, and then a STOP. A master reads at any location by first setting the word address in a write-addressed transaction, then issuing a repeated START with R/W high and clocking out data bytes. It ends the read with a NACK and a STOP.

A STOP that closes a transaction carrying a data byte starts an internal programming interval of WR_CYCLES clocks. The byte reaches the array only when that interval ends. While it runs, the device refuses its own identity with a NACK. A master finds out when the write is finished by repeating START plus the identity until it gets an ACK.

The block samples SCL and SDA through synchronisers in the system clock domain. It pulls SDA low through an open-drain style enable output and never drives SCL.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: When no programming interval is running, an address byte whose upper seven bits equal DEV_ID is acknowledged by holding SDA low through the ninth SCL pulse. Bit 0 selects the direction: 0 means write (0xA0 by default) and 1 means read (0xA1 by default).
- R2: In a write-addressed transaction, the first byte after the address byte loads the word pointer, and each later byte is a data byte. The device acknowledges every one of these bytes.
- R3: A STOP received after at least one data byte starts a programming interval of WR_CYCLES clocks. The array takes the last data byte, at its word address, only when that interval ends.
- R4: While the programming interval runs, the device leaves SDA released for an address byte that matches DEV_ID, so that byte is not acknowledged. The first address byte after the interval ends is acknowledged.
- R5: After a read-addressed ACK, the device shifts out the byte at the word pointer, most significant bit first. Each bit is driven while SCL is low.
- R6: The word pointer advances by one after each data byte written or read, and it wraps from 0xFF to 0x00.
- R7: When the master NACKs a read byte, the device releases SDA and drives nothing until the next START.
- R8: An address byte whose upper seven bits differ from DEV_ID is not acknowledged. SDA stays released for the rest of that transaction, and the array is unchanged.
- R9: A STOP or a START at any point returns the device to address reception with SDA released. A START discards a written data byte that no STOP has yet closed, so no programming interval follows.
- R10: Reset releases SDA, ends any programming interval and sets the word pointer to 0x00. Array contents are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_low_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench builds the block with DEV_ID 0x50, an 8-bit word address, two synchroniser stages and WR_CYCLES set to 600. With that interval, the first polling attempt after a STOP always arrives while the device is busy, and a later attempt arrives after it has finished. Each write therefore exercises both the NACK and the ACK outcome of acknowledge polling. A full 256-byte array lets the bench read across the 0xFF to 0x00 pointer wrap. A bit time of 32 clocks gives the synchronisers margin on every SCL and SDA transition.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_WADR,
      ST_WADR_ACK,
      ST_WDAT,
      ST_WDAT_ACK,
      ST_RDAT,
      ST_RACK
   } ee_state_t;

   localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] scl_q;
   logic [SYNC_STAGES-1:0] sda_q;
   logic scl_d, sda_d, scl_s;

   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_q[0] <= 1'b1;
               sda_q[0] <= 1'b1;
            end else begin
               scl_q[0] <= scl_i;
               sda_q[0] <= sda_i;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_q[g] <= 1'b1;
               sda_q[g] <= 1'b1;
            end else begin
               scl_q[g] <= scl_q[g-1];
               sda_q[g] <= sda_q[g-1];
            end
         end
      end
   end

   assign scl_s = scl_q[SYNC_STAGES-1];
   assign sda_s = sda_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/ee_prog_timer.sv
module ee_prog_timer #(
   parameter int unsigned CYCLES = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int unsigned CW = $clog2(CYCLES + 1);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - 1'b1;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= CW'(CYCLES - 1);
      end
   end

   assign done = busy && (cnt == '0);

   p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   p_done_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
endmodule

// File: rtl/ee_array.sv
module ee_array #(
   parameter int unsigned AW = 8,
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
   import i2c_ee_pkg::*;
#(
   parameter logic [6:0]  DEV_ID      = 7'h50,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned WR_CYCLES   = 5000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_low_o
);
   localparam logic [ADDR_W-1:0] PTR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};
   localparam logic [ADDR_W-1:0] PTR_TOP = {ADDR_W{1'b1}};

   if (ADDR_W < 1 || ADDR_W > BYTE_W) begin : g_bad_aw
      $error("ADDR_W must lie in 1..8");
   end

   logic sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic busy, tmr_done, tmr_start;
   logic [BYTE_W-1:0] rd_byte;

   ee_state_t           state;
   logic [2:0]          bit_cnt;
   logic                byte_done, ack_seen, rd_req, sda_low;
   logic [BYTE_W-1:0]   rx_sh, tx_sh, pend_data;
   logic [ADDR_W-1:0]   ptr, pend_addr;
   logic                pend_valid;

   i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   assign tmr_start = stop_det && pend_valid && !busy;

   ee_prog_timer #(.CYCLES(WR_CYCLES)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start(tmr_start), .busy(busy), .done(tmr_done)
   );

   ee_array #(.AW(ADDR_W), .DW(BYTE_W)) u_mem (
      .clk(clk), .we(tmr_done), .waddr(pend_addr), .wdata(pend_data),
      .raddr(ptr), .rdata(rd_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         bit_cnt    <= '0;
         byte_done  <= 1'b0;
         ack_seen   <= 1'b0;
         rd_req     <= 1'b0;
         sda_low    <= 1'b0;
         rx_sh      <= '0;
         tx_sh      <= '0;
         ptr        <= '0;
         pend_addr  <= '0;
         pend_data  <= '0;
         pend_valid <= 1'b0;
      end else if (start_det) begin
         state      <= ST_DEV;
         bit_cnt    <= '0;
         byte_done  <= 1'b0;
         ack_seen   <= 1'b0;
         sda_low    <= 1'b0;
         pend_valid <= 1'b0;
      end else if (stop_det) begin
         state      <= ST_IDLE;
         byte_done  <= 1'b0;
         ack_seen   <= 1'b0;
         sda_low    <= 1'b0;
         pend_valid <= 1'b0;
      end else begin
         unique case (state)
            ST_DEV, ST_WADR, ST_WDAT: begin
               if (scl_rise) begin
                  rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
                  bit_cnt <= bit_cnt + 3'd1;
                  if (bit_cnt == 3'd7) byte_done <= 1'b1;
               end else if (scl_fall && byte_done) begin
                  byte_done <= 1'b0;
                  if (state == ST_DEV) begin
                     if (rx_sh[7:1] == DEV_ID && !busy) begin
                        rd_req  <= rx_sh[0];
                        sda_low <= 1'b1;
                        state   <= ST_DEV_ACK;
                     end else begin
                        state   <= ST_IDLE;
                     end
                  end else if (state == ST_WADR) begin
                     ptr     <= rx_sh[ADDR_W-1:0];
                     sda_low <= 1'b1;
                     state   <= ST_WADR_ACK;
                  end else begin
                     pend_addr  <= ptr;
                     pend_data  <= rx_sh;
                     pend_valid <= 1'b1;
                     ptr        <= ptr + PTR_ONE;
                     sda_low    <= 1'b1;
                     state      <= ST_WDAT_ACK;
                  end
               end
            end
            ST_DEV_ACK: begin
               if (scl_fall) begin
                  bit_cnt <= '0;
                  if (rd_req) begin
                     tx_sh   <= rd_byte;
                     sda_low <= ~rd_byte[7];
                     ptr     <= ptr + PTR_ONE;
                     state   <= ST_RDAT;
                  end else begin
                     sda_low <= 1'b0;
                     state   <= ST_WADR;
                  end
               end
            end
            ST_WADR_ACK, ST_WDAT_ACK: begin
               if (scl_fall) begin
                  sda_low <= 1'b0;
                  bit_cnt <= '0;
                  state   <= ST_WDAT;
               end
            end
            ST_RDAT: begin
               if (scl_fall) begin
                  if (bit_cnt == 3'd7) begin
                     sda_low <= 1'b0;
                     bit_cnt <= '0;
                     state   <= ST_RACK;
                  end else begin
                     tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
                     sda_low <= ~tx_sh[6];
                     bit_cnt <= bit_cnt + 3'd1;
                  end
               end
            end
            ST_RACK: begin
               if (scl_rise) begin
                  if (sda_s) state <= ST_IDLE;
                  else       ack_seen <= 1'b1;
               end else if (scl_fall && ack_seen) begin
                  ack_seen <= 1'b0;
                  bit_cnt  <= '0;
                  tx_sh    <= rd_byte;
                  sda_low  <= ~rd_byte[7];
                  ptr      <= ptr + PTR_ONE;
                  state    <= ST_RDAT;
               end
            end
            default: begin
               sda_low <= 1'b0;
            end
         endcase
      end
   end

   assign sda_low_o = sda_low;

   // R4: an address decision taken while busy never drives SDA
   p_busy_nack_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DEV && scl_fall && byte_done && busy && !start_det && !stop_det)
      |=> !sda_low_o);
   // R3: no write is waiting for a STOP while the array is being programmed
   p_no_pend_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !pend_valid);
   // R8 / R7: in the idle state the line is released
   p_idle_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_low_o);
   // R9: a STOP always releases SDA
   p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_low_o);
   // R6: the pointer steps from its top value to zero
   p_ptr_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ptr) == PTR_TOP && $past(state) != ST_WADR && ptr != $past(ptr))
      |-> ptr == '0);
endmodule

// File: tb/tb_i2c_eeprom_slave.sv
module tb_i2c_eeprom_slave;
   localparam int unsigned WRC = 600;
   localparam int unsigned Q   = 8;
   localparam logic [7:0] A_WR = 8'hA0;
   localparam logic [7:0] A_RD = 8'hA1;
   localparam logic [15:0] VEC [0:5] = '{16'h005A, 16'h01C3, 16'h1011,
                                         16'h1122, 16'h7F80, 16'hFFE7};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_low;
   logic sda_bus;
   int   checks = 0;
   int   fails  = 0;
   int   viol   = 0;
   bit   watch  = 1'b0;
   bit   ended  = 1'b0;

   always #4 clk = ~clk;

   assign sda_bus = sda_m & ~sda_low;

   i2c_eeprom_slave #(.DEV_ID(7'h50), .ADDR_W(8), .WR_CYCLES(WRC), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_low_o(sda_low)
   );

   always @(negedge clk) if (watch && sda_low) viol++;

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!ended) begin
         ended = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   task automatic i2c_start();
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b1; tick(Q);
   endtask

   task automatic wbit(input logic b);
      sda_m = b;    tick(Q);
      scl_m = 1'b1; tick(2 * Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic rbit(output logic b);
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      b = sda_bus;  tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic wbyte(input logic [7:0] d, output logic nack);
      for (int b = 7; b >= 0; b--) wbit(d[b]);
      rbit(nack);
   endtask

   task automatic rbyte(input logic nack, output logic [7:0] d);
      logic x;
      for (int b = 7; b >= 0; b--) begin
         rbit(x);
         d[b] = x;
      end
      wbit(nack);
   endtask

   task automatic do_write(input logic [7:0] a, input logic [7:0] d);
      logic n;
      int polls;
      i2c_start();
      wbyte(A_WR, n); chk("R1 write address ack", n, 0);
      wbyte(a, n);    chk("R2 word address ack", n, 0);
      wbyte(d, n);    chk("R2 data ack", n, 0);
      i2c_stop();
      polls = 0;
      n = 1'b1;
      for (int k = 0; k < 40 && n; k++) begin
         i2c_start();
         wbyte(A_WR, n);
         if (n) polls++;
      end
      i2c_stop();
      chk("R3 R4 busy polls seen", 32'(polls > 0), 1);
      chk("R4 ack after write cycle", n, 0);
   endtask

   task automatic set_ptr(input logic [7:0] a);
      logic n;
      i2c_start();
      wbyte(A_WR, n); chk("R1 dummy write ack", n, 0);
      wbyte(a, n);    chk("R2 pointer load ack", n, 0);
      i2c_start();
      wbyte(A_RD, n); chk("R1 read address ack", n, 0);
   endtask

   initial begin
      logic [7:0] d;
      logic n;
      tick(10);
      chk("R10 sda released in reset", sda_low, 0);
      rst_n = 1'b1;
      tick(10);
      chk("R10 sda released after reset", sda_low, 0);

      for (int i = 0; i < 6; i++) do_write(VEC[i][15:8], VEC[i][7:0]);
      for (int i = 0; i < 6; i++) begin
         set_ptr(VEC[i][15:8]);
         rbyte(1'b1, d);
         i2c_stop();
         chk("R5 random read data", d, VEC[i][7:0]);
      end

      // R6 sequential read and pointer wrap
      set_ptr(8'h10);
      rbyte(1'b0, d); chk("R6 first byte", d, 8'h11);
      rbyte(1'b1, d); chk("R6 incremented byte", d, 8'h22);
      i2c_stop();
      set_ptr(8'hFF);
      rbyte(1'b0, d); chk("R6 byte at top", d, 8'hE7);
      rbyte(1'b1, d); chk("R6 wrap to zero", d, 8'h5A);
      i2c_stop();

      // R7 nothing driven after a master NACK
      set_ptr(8'h01);
      rbyte(1'b1, d); chk("R7 byte before nack", d, 8'hC3);
      viol = 0; watch = 1'b1;
      rbyte(1'b1, d);
      watch = 1'b0;
      chk("R7 line idle after nack", d, 8'hFF);
      chk("R7 no drive after nack", viol, 0);
      i2c_stop();

      // R8 foreign address ignored
      viol = 0; watch = 1'b1;
      i2c_start();
      wbyte(8'hA4, n); chk("R8 foreign address nack", n, 1);
      wbyte(8'h01, n); chk("R8 following byte nack", n, 1);
      wbyte(8'h00, n);
      i2c_stop();
      watch = 1'b0;
      chk("R8 never driven", viol, 0);
      set_ptr(8'h01);
      rbyte(1'b1, d); i2c_stop();
      chk("R8 array unchanged", d, 8'hC3);

      // R9 repeated START discards an unclosed write
      i2c_start();
      wbyte(A_WR, n); wbyte(8'h7F, n); wbyte(8'h33, n);
      i2c_start();
      wbyte(A_WR, n); chk("R9 ack after restart", n, 0);
      i2c_stop();
      i2c_start();
      wbyte(A_WR, n); chk("R9 no write cycle started", n, 0);
      i2c_stop();
      set_ptr(8'h7F);
      rbyte(1'b1, d); i2c_stop();
      chk("R9 discarded write left data", d, 8'h80);

      // R10 reset ends the write cycle and clears the pointer
      i2c_start();
      wbyte(A_WR, n); wbyte(8'h40, n); wbyte(8'h44, n);
      i2c_stop();
      rst_n = 1'b0; tick(4);
      chk("R10 released during reset", sda_low, 0);
      rst_n = 1'b1; tick(4);
      i2c_start();
      wbyte(A_RD, n); chk("R10 ack right after reset", n, 0);
      rbyte(1'b1, d); i2c_stop();
      chk("R10 pointer at zero", d, 8'h5A);

      summary();
   end

   initial begin
      repeat (150000) @(posedge clk);
      #1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
   end
endmodule